// File: doc/BRIEF.md
# Packet Filter VM Arithmetic Unit

This unit runs the arithmetic instructions of a 64-bit register virtual machine used for packet filtering. The core supplies an 8-bit opcode, the current destination register value, the source register value and the 32-bit immediate, and pulses `start`. The unit applies the operation and returns the 64-bit result with a write-enable for the destination register. Register file access, fetch, branches and memory traffic are handled elsewhere.

The low three opcode bits select between a 32-bit and a 64-bit operand class. Bit 3 chooses the immediate or the source register as the second operand. The top nibble names the operation. Most operations finish in one clock. Unsigned divide and modulo use a radix-2 iterative divider, which holds `busy` high until it finishes. Opcodes the unit does not recognise complete with `illegal` set, and they write nothing.

Top module: `vm_alu`

## Requirements
- R1: Decode. `opcode[2:0]` = 4 selects the 32-bit class and 7 selects the 64-bit class. `opcode[3]` = 1 takes the source register and 0 takes the immediate. `opcode[7:4]` is the operation: 0 add, 1 subtract, 2 multiply, 3 divide, 4 or, 5 and, 6 shift left, 7 logical shift right, 8 complement, 9 modulo, 10 xor, 11 move, 12 arithmetic shift right, 13 byte order.
- R2: A legal operation other than divide or modulo is accepted on a clock edge with `start` high and `busy` low. In the next cycle `done` and `wr_en` are high for one cycle and `result` holds the value. Results wrap modulo 2^64.
- R3: In the 32-bit class both operands are cut to their low 32 bits, and `result[63:32]` is zero for every operation except byte order.
- R4: In the 64-bit class the immediate is sign-extended to 64 bits, and this includes divide and modulo. In the 32-bit class it is zero-extended.
- R5: The shift amount is the second operand masked with 63 in the 64-bit class and with 31 in the 32-bit class. Arithmetic shift right fills with bit 63 or with bit 31, matching the class.
- R6: Complement (8) returns the bitwise inverse of the second operand, and move (11) returns the second operand.
- R7: Divide and modulo are unsigned. After the accepting edge `busy` is high, and `done` with `wr_en` arrives on the 64th edge after the accepting edge, in the same cycle that `busy` falls.
- R8: Divide by zero yields 0. Modulo by zero yields the destination value unchanged in the 64-bit class, and its low 32 bits zero-extended in the 32-bit class.
- R9: Byte order (13) in either class uses the full 64-bit destination value and ignores the source register. The immediate gives the width as 16, 32 or 64. With `opcode[3]` = 0 the low bytes of that width are kept and zero-extended. With `opcode[3]` = 1 the bytes within that width are reversed and zero-extended.
- R10: A class other than 4 or 7, an operation of 14 or 15, or a byte-order width other than 16, 32 or 64 completes in one cycle with `done` and `illegal` high, `wr_en` low and `result` zero.
- R11: `start` while `busy` is high is ignored: it produces no extra `done` and does not change the pending divide result.
- R12: While `rst_n` is low, `done`, `busy`, `wr_en`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue the presented instruction |
| opcode | input | 8 | Operation, operand source and class |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Instruction immediate |
| busy | output | 1 | Divider iterating; new starts are ignored |
| done | output | 1 | One-cycle completion strobe |
| wr_en | output | 1 | Destination register must be written with `result` |
| illegal | output | 1 | Completed instruction was not recognised |
| result | output | 64 | Value for the destination register |

## Verification
A single-cycle operation shows its outcome in the cycle after the edge that samples `start`. A divide or modulo shows it in the cycle after the 64th edge that follows the accepting edge. For every instruction the driver records the cycle count at which the outcome is due, and the monitor checks the value, the write-enable, the illegal flag and the arrival cycle together. Any `done` that appears with nothing expected, such as one caused by a start issued while the divider is busy, is reported as a failure.

// File: rtl/vm_alu_pkg.sv
`timescale 1ns/1ps
// vm_alu_pkg: shared encodings for the VM arithmetic unit.
// Assumes the opcode layout {operation[3:0], source_sel, class[2:0]}.
package vm_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'ha,
        OP_MOV  = 4'hb,
        OP_ARSH = 4'hc,
        OP_SWAP = 4'hd,
        OP_RSVE = 4'he,
        OP_RSVF = 4'hf
    } alu_op_e;

    localparam logic [2:0] CLS_NARROW = 3'd4;
    localparam logic [2:0] CLS_WIDE   = 3'd7;

    function automatic logic op_is_divide(input alu_op_e o);
        return (o == OP_DIV) || (o == OP_MOD);
    endfunction

endpackage

// File: rtl/vm_alu_operand.sv
`timescale 1ns/1ps
// vm_alu_operand: picks and extends the two operands.
// Narrow class: operands cut to W/2 bits, immediate zero-extended.
// Wide class: immediate sign-extended to W bits.
module vm_alu_operand #(
    parameter int W  = 64,
    parameter int IW = 32
) (
    input  logic [7:0]    opcode,
    input  logic [W-1:0]  dst_val,
    input  logic [W-1:0]  src_val,
    input  logic [IW-1:0] imm,
    output logic [W-1:0]  opa,
    output logic [W-1:0]  opb,
    output logic          wide,
    output logic          class_ok
);
    import vm_alu_pkg::*;

    localparam int HW = W / 2;

    logic [W-1:0] imm_ext;
    logic [W-1:0] raw_b;

    // Class decode
    always_comb begin
        wide     = (opcode[2:0] == CLS_WIDE);
        class_ok = wide || (opcode[2:0] == CLS_NARROW);
    end

    // Immediate extension and source selection
    always_comb begin
        imm_ext = wide ? {{(W-IW){imm[IW-1]}}, imm} : {{(W-IW){1'b0}}, imm};
        raw_b   = opcode[3] ? src_val : imm_ext;
    end

    // Operand truncation for the narrow class
    always_comb begin
        if (wide) begin
            opa = dst_val;
            opb = raw_b;
        end else begin
            opa = {{HW{1'b0}}, dst_val[HW-1:0]};
            opb = {{HW{1'b0}}, raw_b[HW-1:0]};
        end
    end
endmodule

// File: rtl/vm_alu_simple.sv
`timescale 1ns/1ps
// vm_alu_simple: all single-cycle operations, combinational.
// Assumes operands already prepared by vm_alu_operand; byte-order
// conversion works on the unmodified destination value, host is little-endian.
module vm_alu_simple #(
    parameter int W  = 64,
    parameter int IW = 32
) (
    input  vm_alu_pkg::alu_op_e op,
    input  logic                wide,
    input  logic [W-1:0]        opa,
    input  logic [W-1:0]        opb,
    input  logic [W-1:0]        dst_raw,
    input  logic                to_big,
    input  logic [IW-1:0]       imm,
    output logic [W-1:0]        res,
    output logic                width_bad
);
    import vm_alu_pkg::*;

    localparam int HW  = W / 2;
    localparam int NB  = W / 8;
    localparam int SHW = $clog2(W);
    localparam int BIW = $clog2(NB);

    logic [SHW-1:0] shamt;
    logic [W-1:0]   sext_a;
    logic [W-1:0]   calc;
    logic [W-1:0]   swapped;
    logic [BIW:0]   nbytes;

    // Shift amount mask by class
    always_comb begin
        shamt  = wide ? opb[SHW-1:0] : {1'b0, opb[SHW-2:0]};
        sext_a = wide ? opa : {{HW{opa[HW-1]}}, opa[HW-1:0]};
    end

    // Byte-order width decode
    always_comb begin
        width_bad = 1'b0;
        case (imm)
            32'd16:  nbytes = (BIW+1)'(2);
            32'd32:  nbytes = (BIW+1)'(4);
            32'd64:  nbytes = (BIW+1)'(8);
            default: begin
                nbytes    = '0;
                width_bad = 1'b1;
            end
        endcase
    end

    // Byte selection within the requested width
    always_comb begin
        swapped = '0;
        for (int k = 0; k < NB; k++) begin
            if ((BIW+1)'(k) < nbytes) begin
                if (to_big)
                    swapped[8*k +: 8] = dst_raw[{BIW'(nbytes - (BIW+1)'(1) - (BIW+1)'(k)), 3'b000} +: 8];
                else
                    swapped[8*k +: 8] = dst_raw[8*k +: 8];
            end
        end
    end

    // Operation select
    always_comb begin
        case (op)
            OP_ADD:  calc = opa + opb;
            OP_SUB:  calc = opa - opb;
            OP_MUL:  calc = opa * opb;
            OP_OR:   calc = opa | opb;
            OP_AND:  calc = opa & opb;
            OP_XOR:  calc = opa ^ opb;
            OP_LSH:  calc = opa << shamt;
            OP_RSH:  calc = opa >> shamt;
            OP_ARSH: calc = W'($signed(sext_a) >>> shamt);
            OP_NEG:  calc = ~opb;
            OP_MOV:  calc = opb;
            default: calc = '0;
        endcase
    end

    // Class-width result trimming
    always_comb begin
        if (op == OP_SWAP)
            res = swapped;
        else if (wide)
            res = calc;
        else
            res = {{HW{1'b0}}, calc[HW-1:0]};
    end
endmodule

// File: rtl/vm_alu_divider.sv
`timescale 1ns/1ps
// vm_alu_divider: restoring radix-2 unsigned divider, one quotient bit
// per clock for W clocks after load. Exposes the values of the final step
// so the owner can capture them on the last busy edge.
module vm_alu_divider #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         last,
    output logic [W-1:0] quot_nxt,
    output logic [W-1:0] rem_nxt
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  quo_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    trial;
    logic [W:0]    diff;
    logic          fits;

    // One restoring step
    always_comb begin
        trial    = {rem_q, quo_q[W-1]};
        fits     = trial >= {1'b0, den_q};
        diff     = trial - {1'b0, den_q};
        rem_nxt  = fits ? diff[W-1:0] : trial[W-1:0];
        quot_nxt = {quo_q[W-2:0], fits};
        busy     = (cnt_q != '0);
        last     = (cnt_q == CW'(1));
    end

    // Iteration state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            quo_q <= dividend;
            rem_q <= '0;
            den_q <= divisor;
            cnt_q <= CW'(W);
        end else if (busy) begin
            quo_q <= quot_nxt;
            rem_q <= rem_nxt;
            cnt_q <= cnt_q - CW'(1);
        end
    end
endmodule

// File: rtl/vm_alu.sv
`timescale 1ns/1ps
// vm_alu: arithmetic execution unit of a 64-bit register VM.
// Single-cycle ops complete on the accepting edge; divide and modulo
// run the iterative divider and complete W edges later. Starts while
// busy are dropped. Illegal encodings complete without a write.
module vm_alu #(
    parameter int W  = 64,
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [W-1:0]  dst_val,
    input  logic [W-1:0]  src_val,
    input  logic [IW-1:0] imm,
    output logic          busy,
    output logic          done,
    output logic          wr_en,
    output logic          illegal,
    output logic [W-1:0]  result
);
    import vm_alu_pkg::*;

    alu_op_e      op;
    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic         wide;
    logic         class_ok;
    logic [W-1:0] simple_res;
    logic         width_bad;
    logic         bad_code;
    logic         accept;
    logic         div_load;
    logic         div_last;
    logic [W-1:0] div_quot;
    logic [W-1:0] div_rem;
    logic         pend_mod;
    logic         pend_zero;
    logic [W-1:0] pend_a;

    vm_alu_operand #(.W(W), .IW(IW)) u_operand (
        .opcode   (opcode),
        .dst_val  (dst_val),
        .src_val  (src_val),
        .imm      (imm),
        .opa      (opa),
        .opb      (opb),
        .wide     (wide),
        .class_ok (class_ok)
    );

    vm_alu_simple #(.W(W), .IW(IW)) u_simple (
        .op        (op),
        .wide      (wide),
        .opa       (opa),
        .opb       (opb),
        .dst_raw   (dst_val),
        .to_big    (opcode[3]),
        .imm       (imm),
        .res       (simple_res),
        .width_bad (width_bad)
    );

    vm_alu_divider #(.W(W)) u_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .dividend (opa),
        .divisor  (opb),
        .busy     (busy),
        .last     (div_last),
        .quot_nxt (div_quot),
        .rem_nxt  (div_rem)
    );

    // Legality and issue decode
    always_comb begin
        op       = alu_op_e'(opcode[7:4]);
        bad_code = !class_ok || (op == OP_RSVE) || (op == OP_RSVF) ||
                   ((op == OP_SWAP) && width_bad);
        accept   = start && !busy;
        div_load = accept && !bad_code && op_is_divide(op);
    end

    // Pending divide context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_mod  <= 1'b0;
            pend_zero <= 1'b0;
            pend_a    <= '0;
        end else if (div_load) begin
            pend_mod  <= (op == OP_MOD);
            pend_zero <= (opb == '0);
            pend_a    <= opa;
        end
    end

    // Completion outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            wr_en   <= 1'b0;
            illegal <= 1'b0;
            result  <= '0;
        end else begin
            done    <= 1'b0;
            wr_en   <= 1'b0;
            illegal <= 1'b0;
            if (accept && bad_code) begin
                done    <= 1'b1;
                illegal <= 1'b1;
                result  <= '0;
            end else if (accept && !op_is_divide(op)) begin
                done   <= 1'b1;
                wr_en  <= 1'b1;
                result <= simple_res;
            end else if (div_last) begin
                done  <= 1'b1;
                wr_en <= 1'b1;
                if (pend_zero)
                    result <= pend_mod ? pend_a : '0;
                else
                    result <= pend_mod ? div_rem : div_quot;
            end
        end
    end
endmodule

// File: rtl/vm_alu_checker.sv
`timescale 1ns/1ps
// vm_alu_checker: protocol properties of vm_alu, bound to every instance.
module vm_alu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [7:0]  opcode,
    input logic        busy,
    input logic        done,
    input logic        wr_en,
    input logic        illegal,
    input logic [63:0] result
);
    logic good_cls;
    logic single_op;
    logic narrow_trim;
    logic div_op;

    // Encoding groups seen from the ports
    always_comb begin
        good_cls    = (opcode[2:0] == 3'd4) || (opcode[2:0] == 3'd7);
        div_op      = good_cls && ((opcode[7:4] == 4'h3) || (opcode[7:4] == 4'h9));
        single_op   = good_cls && (opcode[7:4] < 4'hd) && !div_op;
        narrow_trim = single_op && (opcode[2:0] == 3'd4);
    end

    assert_illegal_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!wr_en && result == 64'd0));

    assert_single_next_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && single_op) |=> (done && wr_en && !illegal));

    assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && narrow_trim) |=> (result[63:32] == 32'd0));

    assert_divide_goes_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && div_op) |=> busy);

    assert_done_when_busy_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && wr_en));

    assert_no_done_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
endmodule

bind vm_alu vm_alu_checker u_vm_alu_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opcode  (opcode),
    .busy    (busy),
    .done    (done),
    .wr_en   (wr_en),
    .illegal (illegal),
    .result  (result)
);

// File: tb/tb_vm_alu.sv
`timescale 1ns/1ps
// tb_vm_alu: scoreboard bench. The driver queues expected outcomes with
// their due cycle; the monitor pops one on every done strobe.
module tb_vm_alu;

    localparam int DIV_LAT = 65;

    typedef struct {
        logic [63:0] res;
        logic        wr;
        logic        ill;
        int          due;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  opcode;
    logic [63:0] dst_val;
    logic [63:0] src_val;
    logic [31:0] imm;
    logic        busy;
    logic        done;
    logic        wr_en;
    logic        illegal;
    logic [63:0] result;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    exp_t sb[$];

    vm_alu dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .opcode  (opcode),
        .dst_val (dst_val),
        .src_val (src_val),
        .imm     (imm),
        .busy    (busy),
        .done    (done),
        .wr_en   (wr_en),
        .illegal (illegal),
        .result  (result)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares each completion against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11 unexpected done", result, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(result == e.res, {e.tag, " result"}, result, e.res);
                check(wr_en == e.wr, {e.tag, " wr_en"}, 64'(wr_en), 64'(e.wr));
                check(illegal == e.ill, {e.tag, " illegal"}, 64'(illegal), 64'(e.ill));
                check(cyc == e.due, {e.tag, " latency"}, 64'(cyc), 64'(e.due));
            end
        end
    end

    task automatic run(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                       input logic [31:0] i, input logic [63:0] exp, input bit wr,
                       input bit ill, input int lat, input string tag);
        @(negedge clk);
        opcode  = op;
        dst_val = d;
        src_val = s;
        imm     = i;
        start   = 1'b1;
        sb.push_back('{exp, wr, ill, cyc + lat, tag});
        @(negedge clk);
        start = 1'b0;
        while (sb.size() != 0) @(posedge clk);
    endtask

    task automatic simple(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                          input logic [31:0] i, input logic [63:0] exp, input string tag);
        run(op, d, s, i, exp, 1'b1, 1'b0, 1, tag);
    endtask

    task automatic divop(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                         input logic [31:0] i, input logic [63:0] exp, input string tag);
        run(op, d, s, i, exp, 1'b1, 1'b0, DIV_LAT, tag);
    endtask

    task automatic bad(input logic [7:0] op, input logic [31:0] i, input string tag);
        run(op, 64'h1111_2222_3333_4444, 64'h5, i, 64'd0, 1'b0, 1'b1, 1, tag);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // Stimulus
    initial begin
        rst_n   = 1'b0;
        start   = 1'b0;
        opcode  = 8'h0;
        dst_val = 64'h0;
        src_val = 64'h0;
        imm     = 32'h0;
        repeat (3) @(negedge clk);
        check({done, busy, wr_en, illegal} == 4'b0, "R12 reset flags", 64'({done, busy, wr_en, illegal}), 64'd0);
        check(result == 64'd0, "R12 reset result", result, 64'd0);
        rst_n = 1'b1;

        // R1 R2: wide add from register, wrap
        simple(8'h0f, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 32'h0, 64'd1, "R1 R2 add64 wrap");
        // R3: narrow add truncates and wraps
        simple(8'h0c, 64'h1234_5678_FFFF_FFFF, 64'h9999_0000_0000_0001, 32'h0, 64'd0, "R3 add32");
        // R4: wide immediate sign-extended
        simple(8'h17, 64'd10, 64'd0, 32'hFFFF_FFFF, 64'd11, "R4 sub64 imm");
        // R4: narrow immediate zero-extended
        simple(8'h14, 64'd5, 64'd0, 32'hFFFF_FFFF, 64'd6, "R4 sub32 imm");
        simple(8'h2f, 64'h1_0000_0001, 64'h1_0000_0001, 32'h0, 64'h2_0000_0001, "R1 mul64");
        simple(8'h4f, 64'hF0F0, 64'h0F0F_0000_0000_0000, 32'h0, 64'h0F0F_0000_0000_F0F0, "R1 or64");
        simple(8'h5f, 64'hFF00_FF00_FF00_FF00, 64'h0FF0_0FF0_0FF0_0FF0, 32'h0, 64'h0F00_0F00_0F00_0F00, "R1 and64");
        simple(8'haf, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_0000_0000, 32'h0, 64'h5555_5555_AAAA_AAAA, "R1 xor64");
        // R5: shift masks and arithmetic fill
        simple(8'h6f, 64'd3, 64'd65, 32'h0, 64'd6, "R5 lsh64 mask");
        simple(8'h6c, 64'h8000_0001, 64'd33, 32'h0, 64'd2, "R5 lsh32 mask");
        simple(8'h7f, 64'h8000_0000_0000_0000, 64'd63, 32'h0, 64'd1, "R5 rsh64");
        simple(8'hcf, 64'h8000_0000_0000_0000, 64'd4, 32'h0, 64'hF800_0000_0000_0000, "R5 arsh64");
        simple(8'hcc, 64'h0000_0000_8000_0000, 64'd36, 32'h0, 64'h0000_0000_F800_0000, "R5 arsh32");
        // R6: complement and move
        simple(8'h8f, 64'h1234, 64'h00FF, 32'h0, 64'hFFFF_FFFF_FFFF_FF00, "R6 neg64 reg");
        simple(8'h84, 64'h1234, 64'h0, 32'h0000_00FF, 64'h0000_0000_FFFF_FF00, "R6 neg32 imm");
        simple(8'hb7, 64'h1234, 64'h0, 32'h8000_0000, 64'hFFFF_FFFF_8000_0000, "R6 R4 mov64 imm");
        simple(8'hb4, 64'h1234, 64'h0, 32'h8000_0000, 64'h0000_0000_8000_0000, "R6 R3 mov32 imm");
        // R7: divide and modulo
        divop(8'h3f, 64'd100, 64'd7, 32'h0, 64'd14, "R7 div64");
        divop(8'h9f, 64'd100, 64'd7, 32'h0, 64'd2, "R7 mod64");
        divop(8'h37, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 64'd1, "R7 R4 div64 imm");
        divop(8'h34, 64'h1_FFFF_FFFF, 64'd0, 32'hFFFF_FFFF, 64'd1, "R7 R4 div32 imm");
        divop(8'h9c, 64'hFFFF_FFFF_0000_0011, 64'h1_0000_0005, 32'h0, 64'd2, "R7 R3 mod32");
        // R8: zero divisor
        divop(8'h3f, 64'd123, 64'd0, 32'h0, 64'd0, "R8 div by zero");
        divop(8'h9f, 64'hDEAD_BEEF_0000_0005, 64'd0, 32'h0, 64'hDEAD_BEEF_0000_0005, "R8 mod64 by zero");
        divop(8'h9c, 64'hDEAD_BEEF_0000_0005, 64'd0, 32'h0, 64'h0000_0000_0000_0005, "R8 mod32 by zero");
        // R9: byte order, source register ignored
        simple(8'hd4, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd16, 64'h7788, "R9 le16");
        simple(8'hd4, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd32, 64'h5566_7788, "R9 le32");
        simple(8'hdc, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd16, 64'h8877, "R9 be16");
        simple(8'hdc, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd32, 64'h8877_6655, "R9 be32");
        simple(8'hdc, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd64, 64'h8877_6655_4433_2211, "R9 be64");
        simple(8'hdf, 64'h1122_3344_5566_7788, 64'hFFFF, 32'd64, 64'h8877_6655_4433_2211, "R9 be64 wide class");
        // R10: illegal encodings
        bad(8'hdc, 32'd8, "R10 bad swap width");
        bad(8'he7, 32'd0, "R10 reserved op");
        bad(8'h05, 32'd0, "R10 bad class");

        // R11: start while busy is dropped
        @(negedge clk);
        opcode  = 8'h3f;
        dst_val = 64'd1000;
        src_val = 64'd9;
        imm     = 32'h0;
        start   = 1'b1;
        sb.push_back('{64'd111, 1'b1, 1'b0, cyc + DIV_LAT, "R11 div under overlap"});
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R7 busy during divide", 64'(busy), 64'd1);
        opcode  = 8'h0f;
        dst_val = 64'd1;
        src_val = 64'd1;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (sb.size() != 0) @(posedge clk);
        repeat (6) @(negedge clk);
        check(busy == 1'b0, "R11 idle after divide", 64'(busy), 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule